// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) that accepts one instruction per cycle when nothing stalls. It compares the source register fields of the instruction in decode and in execute with the destination fields held in the later pipeline buffers. From that comparison it produces three things: a select for each ALU operand mux, a select for the store-data mux in the memory stage, and a single-cycle interlock for a load that is followed at once by a consumer of its result.

A small set of pipeline control registers and a register file are wrapped around the comparison logic so that the unit can be driven from decode-stage fields alone. The register file writes in the first half of a cycle and reads in the second half. Because of this, a producer three instructions ahead reaches its consumer through the register file and needs no forwarding path. The ALU datapath itself is not part of the block.

Top module: `fwd_unit`

## Requirements
- R1: After synchronous reset every later stage is empty: both operand selects are 0, the store-data select is 0 and no stall is raised.
- R2: An execute-stage operand whose source is read, is nonzero and equals the destination of a writing non-load instruction in the execute/memory buffer gets select value 1.
- R3: Otherwise, if that source equals the destination of a writing instruction in the memory/writeback buffer (ALU result or load), the select is 2. With no match the select is 0, meaning the register file value.
- R4: When both buffers match the same source, the execute/memory buffer (the younger producer) wins and the select is 1.
- R5: Register index 0 never produces a nonzero select, never sets the store-data select and never causes a stall.
- R6: A source field whose read flag is low (immediate operand or unused) never produces forwarding or a stall.
- R7: When decode reads a nonzero register that a load now in execute writes, hold_fetch and bubble_ex are both high for exactly one cycle, and the decode instruction enters execute on the next cycle.
- R8: The bubble that enters execute on a stall carries no register write, load or store, so it never becomes a forwarding source in later cycles.
- R9: When the instruction in the memory stage is a store whose data register is nonzero and equals the destination of a writing instruction in the memory/writeback buffer, st_data_fwd is 1. Otherwise it is 0.
- R10: A store in decode whose only match against a load in execute is its data register does not stall. Its data is supplied later through R9.
- R11: A register file read returns 0 for index 0, and returns the writeback data written in the same cycle when the writeback destination equals the read index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | 5 | Decode first source index |
| id_rs2 | input | 5 | Decode second source index (store data for stores) |
| id_use_rs1 | input | 1 | Decode instruction reads first source |
| id_use_rs2 | input | 1 | Decode instruction reads second source |
| id_rd | input | 5 | Decode destination index |
| id_wr | input | 1 | Decode instruction writes a register |
| id_load | input | 1 | Decode instruction is a load |
| id_store | input | 1 | Decode instruction is a store |
| wb_wdata | input | XLEN | Result written back this cycle by the writeback stage |
| fwd_a_sel | output | 2 | First ALU operand source: 0 register file, 1 execute/memory, 2 memory/writeback |
| fwd_b_sel | output | 2 | Second operand source, same encoding |
| st_data_fwd | output | 1 | Memory-stage store data taken from memory/writeback buffer |
| hold_fetch | output | 1 | Hold program counter and fetch/decode buffer |
| bubble_ex | output | 1 | Insert empty control into the execute buffer |
| rf_rdata1 | output | XLEN | Register file value for id_rs1 |
| rf_rdata2 | output | XLEN | Register file value for id_rs2 |

## Verification
A corrupted execute, memory or writeback control entry shows up at the operand selects no later than the cycle in which that entry is compared against the consumer. That is one or two cycles after the instruction leaves decode. A bubble that wrongly keeps a write flag appears as a select of 1 on the very next cycle. A missed or doubled stall shows up at once on hold_fetch. It also shifts every later stage by one slot, so select errors keep piling up from then on. A stale register file entry appears on rf_rdata1/2 as soon as decode names that register.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    parameter int REG_IDX_W = 5;

    typedef logic [REG_IDX_W-1:0] ridx_t;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_EXMEM   = 2'd1,
        SRC_MEMWB   = 2'd2
    } opnd_src_e;

    // Control fields carried down the pipeline for one instruction.
    typedef struct packed {
        ridx_t rs1;
        ridx_t rs2;
        logic  use1;
        logic  use2;
        ridx_t rd;
        logic  wr;
        logic  ld;
        logic  st;
    } uop_ctl_t;

    // True when a read source is satisfied by a writing producer.
    function automatic logic dep_hit(ridx_t src, logic used, ridx_t dst, logic wr);
        return used && wr && (src != '0) && (src == dst);
    endfunction
endpackage

// File: rtl/fwd_regfile.sv
module fwd_regfile
    import fwd_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RPORTS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  ridx_t                 waddr,
    input  logic [XLEN-1:0]       wdata,
    input  ridx_t                 raddr [RPORTS],
    output logic [XLEN-1:0]       rdata [RPORTS]
);
    localparam int NREG = 2 ** REG_IDX_W;

    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    // Write-first-half / read-second-half: same-cycle write is visible.
    for (genvar p = 0; p < RPORTS; p++) begin : g_rd
        always_comb begin
            if (raddr[p] == '0)
                rdata[p] = '0;
            else if (we && waddr == raddr[p])
                rdata[p] = wdata;
            else
                rdata[p] = regs[raddr[p]];
        end
    end
endmodule

// File: rtl/fwd_pipe_regs.sv
module fwd_pipe_regs
    import fwd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bubble,
    input  uop_ctl_t id_ctl,
    output uop_ctl_t ex_ctl,
    output uop_ctl_t mem_ctl,
    output uop_ctl_t wb_ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ex_ctl  <= '0;
            mem_ctl <= '0;
            wb_ctl  <= '0;
        end else begin
            ex_ctl  <= bubble ? '0 : id_ctl;
            mem_ctl <= ex_ctl;
            wb_ctl  <= mem_ctl;
        end
    end
endmodule

// File: rtl/fwd_hazard_logic.sv
module fwd_hazard_logic
    import fwd_pkg::*;
(
    input  uop_ctl_t  id_ctl,
    input  uop_ctl_t  ex_ctl,
    input  uop_ctl_t  mem_ctl,
    input  uop_ctl_t  wb_ctl,
    output opnd_src_e opnd_sel [2],
    output logic      st_fwd,
    output logic      stall
);
    ridx_t ex_src [2];
    logic  ex_use [2];
    assign ex_src[0] = ex_ctl.rs1;
    assign ex_src[1] = ex_ctl.rs2;
    assign ex_use[0] = ex_ctl.use1;
    assign ex_use[1] = ex_ctl.use2;

    // A load in the memory stage has no data yet; never take its address.
    logic mem_alu_wr;
    assign mem_alu_wr = mem_ctl.wr && !mem_ctl.ld;

    for (genvar k = 0; k < 2; k++) begin : g_opnd
        always_comb begin
            if (dep_hit(ex_src[k], ex_use[k], mem_ctl.rd, mem_alu_wr))
                opnd_sel[k] = SRC_EXMEM;
            else if (dep_hit(ex_src[k], ex_use[k], wb_ctl.rd, wb_ctl.wr))
                opnd_sel[k] = SRC_MEMWB;
            else
                opnd_sel[k] = SRC_REGFILE;
        end
    end

    assign st_fwd = mem_ctl.st && dep_hit(mem_ctl.rs2, 1'b1, wb_ctl.rd, wb_ctl.wr);

    logic ex_load_wr, hit_a, hit_b;
    assign ex_load_wr = ex_ctl.wr && ex_ctl.ld;
    assign hit_a      = dep_hit(id_ctl.rs1, id_ctl.use1, ex_ctl.rd, ex_load_wr);
    assign hit_b      = dep_hit(id_ctl.rs2, id_ctl.use2, ex_ctl.rd, ex_load_wr);
    // Store data is picked up later in the memory stage, so it never stalls.
    assign stall      = hit_a || (hit_b && !id_ctl.st);
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [REG_IDX_W-1:0] id_rs1,
    input  logic [REG_IDX_W-1:0] id_rs2,
    input  logic                 id_use_rs1,
    input  logic                 id_use_rs2,
    input  logic [REG_IDX_W-1:0] id_rd,
    input  logic                 id_wr,
    input  logic                 id_load,
    input  logic                 id_store,
    input  logic [XLEN-1:0]      wb_wdata,
    output logic [1:0]           fwd_a_sel,
    output logic [1:0]           fwd_b_sel,
    output logic                 st_data_fwd,
    output logic                 hold_fetch,
    output logic                 bubble_ex,
    output logic [XLEN-1:0]      rf_rdata1,
    output logic [XLEN-1:0]      rf_rdata2
);
    uop_ctl_t  id_ctl, ex_ctl, mem_ctl, wb_ctl;
    opnd_src_e sel [2];
    logic      stall, st_fwd;
    ridx_t     rf_ra [2];
    logic [XLEN-1:0] rf_rd [2];

    always_comb begin
        id_ctl      = '0;
        id_ctl.rs1  = id_rs1;
        id_ctl.rs2  = id_rs2;
        id_ctl.use1 = id_use_rs1;
        id_ctl.use2 = id_use_rs2;
        id_ctl.rd   = id_rd;
        id_ctl.wr   = id_wr;
        id_ctl.ld   = id_load;
        id_ctl.st   = id_store;
    end

    fwd_pipe_regs u_pipe (
        .clk    (clk),
        .rst    (rst),
        .bubble (stall),
        .id_ctl (id_ctl),
        .ex_ctl (ex_ctl),
        .mem_ctl(mem_ctl),
        .wb_ctl (wb_ctl)
    );

    fwd_hazard_logic u_haz (
        .id_ctl  (id_ctl),
        .ex_ctl  (ex_ctl),
        .mem_ctl (mem_ctl),
        .wb_ctl  (wb_ctl),
        .opnd_sel(sel),
        .st_fwd  (st_fwd),
        .stall   (stall)
    );

    assign rf_ra[0] = id_rs1;
    assign rf_ra[1] = id_rs2;

    fwd_regfile #(.XLEN(XLEN), .RPORTS(2)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .we   (wb_ctl.wr),
        .waddr(wb_ctl.rd),
        .wdata(wb_wdata),
        .raddr(rf_ra),
        .rdata(rf_rd)
    );

    assign fwd_a_sel   = sel[0];
    assign fwd_b_sel   = sel[1];
    assign st_data_fwd = st_fwd;
    assign hold_fetch  = stall;
    assign bubble_ex   = stall;
    assign rf_rdata1   = rf_rd[0];
    assign rf_rdata2   = rf_rd[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk
    import fwd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       stall,
    input logic [1:0] sel_a,
    input logic [1:0] sel_b,
    input logic       st_fwd,
    input uop_ctl_t   ex_ctl,
    input uop_ctl_t   mem_ctl,
    input uop_ctl_t   wb_ctl
);
    // R7: a load-use interlock lasts one cycle only
    a_r7_single_stall: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    // R8: the bubble entering execute carries no write/load/store
    a_r8_bubble_empty: assert property (@(posedge clk) disable iff (rst)
        stall |=> (!ex_ctl.wr && !ex_ctl.ld && !ex_ctl.st));

    // R5: index 0 is never forwarded
    a_r5_zero_a: assert property (@(posedge clk) disable iff (rst)
        (sel_a != 2'd0) |-> (ex_ctl.rs1 != '0 && ex_ctl.use1));
    a_r5_zero_b: assert property (@(posedge clk) disable iff (rst)
        (sel_b != 2'd0) |-> (ex_ctl.rs2 != '0 && ex_ctl.use2));

    // R4: the older buffer is chosen only if the younger has no match
    a_r4_priority: assert property (@(posedge clk) disable iff (rst)
        (sel_a == 2'd2) |-> !(mem_ctl.wr && !mem_ctl.ld && mem_ctl.rd == ex_ctl.rs1));

    // R9: store-data forwarding only for a store in the memory stage
    a_r9_store_only: assert property (@(posedge clk) disable iff (rst)
        st_fwd |-> (mem_ctl.st && wb_ctl.wr));
endmodule

bind fwd_unit fwd_unit_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .stall  (hold_fetch),
    .sel_a  (fwd_a_sel),
    .sel_b  (fwd_b_sel),
    .st_fwd (st_data_fwd),
    .ex_ctl (ex_ctl),
    .mem_ctl(mem_ctl),
    .wb_ctl (wb_ctl)
);

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
    import fwd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
    logic id_use_rs1 = 0, id_use_rs2 = 0, id_wr = 0, id_load = 0, id_store = 0;
    logic [XLEN-1:0] wb_wdata = '0;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic st_data_fwd, hold_fetch, bubble_ex;
    logic [XLEN-1:0] rf_rdata1, rf_rdata2;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_unit #(.XLEN(XLEN)) uut (
        .clk(clk), .rst(rst),
        .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
        .id_rd(id_rd), .id_wr(id_wr), .id_load(id_load), .id_store(id_store),
        .wb_wdata(wb_wdata),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .st_data_fwd(st_data_fwd), .hold_fetch(hold_fetch), .bubble_ex(bubble_ex),
        .rf_rdata1(rf_rdata1), .rf_rdata2(rf_rdata2)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Bench reference model of the stage contents and register values.
    uop_ctl_t m_ex, m_mem, m_wb;
    logic [XLEN-1:0] m_rf [32];
    logic last_stall = 0;
    uop_ctl_t pend;

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_sel(input logic [4:0] s, input logic u);
        if (u && s != 0 && m_mem.wr && !m_mem.ld && m_mem.rd == s) return 2'd1; // R2 R4
        if (u && s != 0 && m_wb.wr && m_wb.rd == s) return 2'd2;                 // R3
        return 2'd0;
    endfunction

    function automatic logic exp_stall(input uop_ctl_t u);
        logic ha, hb;
        ha = u.use1 && u.rs1 != 0 && m_ex.wr && m_ex.ld && m_ex.rd == u.rs1;
        hb = u.use2 && u.rs2 != 0 && m_ex.wr && m_ex.ld && m_ex.rd == u.rs2;
        return ha || (hb && !u.st);   // R7 R10
    endfunction

    function automatic logic [XLEN-1:0] exp_rd(input logic [4:0] a, input logic [XLEN-1:0] wd);
        if (a == 0) return '0;
        if (m_wb.wr && m_wb.rd == a) return wd;   // R11 same-cycle visibility
        return m_rf[a];
    endfunction

    // Called just after a falling edge: drive, check, then advance one cycle.
    task automatic cycle(input uop_ctl_t u, input string tag);
        logic [XLEN-1:0] wd;
        logic st;
        wd = $urandom;
        id_rs1 = u.rs1; id_rs2 = u.rs2; id_use_rs1 = u.use1; id_use_rs2 = u.use2;
        id_rd = u.rd; id_wr = u.wr; id_load = u.ld; id_store = u.st;
        wb_wdata = wd;
        #1;
        st = exp_stall(u);
        check({tag, " R2_R3_R4_R5_R6 fwd_a"}, {30'b0, fwd_a_sel}, {30'b0, exp_sel(m_ex.rs1, m_ex.use1)});
        check({tag, " R2_R3_R4_R5_R6 fwd_b"}, {30'b0, fwd_b_sel}, {30'b0, exp_sel(m_ex.rs2, m_ex.use2)});
        check({tag, " R9 st_data_fwd"}, {31'b0, st_data_fwd},
              {31'b0, m_mem.st && m_mem.rs2 != 0 && m_wb.wr && m_wb.rd == m_mem.rs2});
        check({tag, " R7_R10 hold_fetch"}, {31'b0, hold_fetch}, {31'b0, st});
        check({tag, " R7 bubble_ex"}, {31'b0, bubble_ex}, {31'b0, st});
        check({tag, " R11 rdata1"}, rf_rdata1, exp_rd(u.rs1, wd));
        check({tag, " R11 rdata2"}, rf_rdata2, exp_rd(u.rs2, wd));
        @(posedge clk);
        if (m_wb.wr && m_wb.rd != 0) m_rf[m_wb.rd] = wd;
        m_wb  = m_mem;
        m_mem = m_ex;
        m_ex  = st ? uop_ctl_t'('0) : u;   // R8 bubble is empty
        last_stall = st;
        @(negedge clk);
    endtask

    function automatic uop_ctl_t mk(input int kind, input int d, input int a, input int b,
                                    input bit ua, input bit ub);
        uop_ctl_t u;
        u = '0;
        u.rs1 = 5'(a); u.rs2 = 5'(b); u.use1 = ua; u.use2 = ub; u.rd = 5'(d);
        case (kind)
            1: begin u.wr = 1; end                      // ALU
            2: begin u.wr = 1; u.ld = 1; u.use2 = 0; end // load
            3: begin u.st = 1; u.use2 = 1; u.rd = 0; end // store
            default: u = '0;                            // nop
        endcase
        return u;
    endfunction

    // Issue an instruction, repeating it while the model says decode is held.
    task automatic issue(input uop_ctl_t u, input string tag);
        cycle(u, tag);
        while (last_stall) cycle(u, tag);
    endtask

    uop_ctl_t nop;

    initial begin
        m_ex = '0; m_mem = '0; m_wb = '0; nop = '0;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        check("R1 fwd_a", {30'b0, fwd_a_sel}, 32'd0);
        check("R1 fwd_b", {30'b0, fwd_b_sel}, 32'd0);
        check("R1 st_fwd", {31'b0, st_data_fwd}, 32'd0);
        check("R1 stall", {31'b0, hold_fetch}, 32'd0);
        @(negedge clk);

        // R2 back-to-back ALU dependence, R3 distance two
        issue(mk(1, 3, 1, 2, 1, 1), "R2 prod");
        issue(mk(1, 4, 3, 0, 1, 0), "R2 cons");
        issue(mk(1, 5, 0, 3, 0, 1), "R3 cons");
        issue(nop, "R3 drain");
        // R4 both buffers match
        issue(mk(1, 6, 0, 0, 0, 0), "R4 old");
        issue(mk(1, 6, 0, 0, 0, 0), "R4 new");
        issue(mk(1, 7, 6, 6, 1, 1), "R4 cons");
        issue(nop, "R4 drain");
        // R5 register zero
        issue(mk(1, 0, 0, 0, 0, 0), "R5 wr0");
        issue(mk(2, 0, 1, 0, 1, 0), "R5 ld0");
        issue(mk(1, 8, 0, 0, 1, 1), "R5 cons");
        issue(nop, "R5 drain");
        // R6 unused sources
        issue(mk(2, 9, 1, 0, 1, 0), "R6 ld");
        issue(mk(1, 10, 9, 9, 0, 0), "R6 imm");
        issue(nop, "R6 drain");
        // R7 load-use stall then R8 bubble, then R3 from load
        issue(mk(2, 11, 2, 0, 1, 0), "R7 ld");
        issue(mk(1, 12, 11, 1, 1, 1), "R7_R8 use");
        issue(nop, "R8 drain");
        issue(nop, "R8 drain");
        // R10 load then store of loaded data, R9 store data forwarding
        issue(mk(2, 13, 2, 0, 1, 0), "R10 ld");
        issue(mk(3, 0, 4, 13, 1, 1), "R10 st");
        issue(nop, "R9 mem");
        issue(nop, "R9 drain");
        // R11 same-cycle write visibility
        issue(mk(1, 14, 0, 0, 0, 0), "R11 prod");
        issue(nop, "R11 gap");
        issue(nop, "R11 gap");
        issue(mk(1, 15, 14, 14, 1, 1), "R11 read");

        for (int n = 0; n < 3000; n++) begin
            pend = mk($urandom_range(0, 3), $urandom_range(0, 4), $urandom_range(0, 4),
                      $urandom_range(0, 4), 1'($urandom), 1'($urandom));
            issue(pend, "RND");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule